// File: doc/BRIEF.md
# I2C Master Transfer Sequencer

This block carries out one complete I2C master transaction on behalf of a host. The host fills a small byte buffer with outgoing data, then pulses `start` together with a slave address byte (bit 0 is the read/write select), a byte count and a repeated-START option. The sequencer then drives a byte-level I2C engine through a command strobe. After each engine step it reads the status code that the engine returns and chooses the next command from it. Bit timing on SCL and SDA stays inside that engine.

The sequencer writes buffer bytes in master-transmit mode. In master-receive mode it requests bytes and passes each received byte out on a one-cycle strobe. It retries on its own after lost arbitration once the bus is free again. It releases the bus on a bus error and ends with STOP when a slave does not acknowledge. It can finish with a repeated START in place of STOP, and an optional timer aborts a transfer that takes too long. The result is reported in four sticky status flags.

Top module: `i2c_xfer_seq`

## Requirements
- R1: After reset the block is idle (`busy`=0), issues no command, and all four status flags read 0.
- R2: Command codes on `eng_cmd` are 1=START, 2=WRITE byte, 3=READ byte, 4=STOP and 5=RELEASE. In idle, a `start` pulse latches the address, count and option. It then issues START, and the first START-sent status (08h, or 10h during a retry) leads to WRITE of the address byte. A `start` pulse while busy has no effect.
- R3: Master write (address bit 0 = 0). Status 18h (address acknowledged) leads to WRITE of buffer entry 0. Each status 28h (byte acknowledged) leads to WRITE of the next entry, in index order, until `count` bytes are sent. The last 28h then leads to STOP and `done`.
- R4: Master read (address bit 0 = 1). Status 40h leads to READ, and each status 50h leads to another READ until `count` bytes are requested. `eng_ack`=1 (acknowledge) goes with every READ except the last, which carries 0. Every 50h or 58h status gives one `rx_valid` pulse with `eng_rx_data` on `rx_data`. Status 58h ends the read with STOP and `done`.
- R5: A count of zero ends the transaction with STOP and `done` right after the address is acknowledged.
- R6: A not-acknowledge status (20h, 30h or 48h) leads to STOP, sets `nack_error` and leaves `done` at 0.
- R7: Status 38h (arbitration lost) sets `arb_lost_retry`. No command is issued while `bus_free` is 0. Once `bus_free` is 1, the whole transaction restarts with START and the first buffer byte.
- R8: Status 00h (bus error), or any status code not listed, leads to RELEASE. The block returns to idle without setting any flag.
- R9: With the repeated-START option set, the final 28h or 58h leads to START in place of STOP. `done` is set when the engine reports 10h.
- R10: If a transaction is still busy TIMEOUT_CYCLES cycles after its start, the block issues RELEASE, sets `timeout` and returns to idle.
- R11: Each status flag, once set, holds until `clear_status` is pulsed. A flag set in the same cycle as the clear stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transaction (ignored while busy) |
| slave_addr | input | 8 | Address byte; bit 0 set selects read |
| byte_count | input | CW | Number of data bytes (at most DEPTH) |
| rep_start_en | input | 1 | End with repeated START instead of STOP |
| buf_we | input | 1 | Buffer write enable |
| buf_waddr | input | IW | Buffer write index |
| buf_wdata | input | 8 | Buffer write data |
| clear_status | input | 1 | Clears all status flags |
| bus_free | input | 1 | Bus idle indication from the line monitor |
| eng_done | input | 1 | Engine finished the last command |
| eng_status | input | 8 | Engine status code for the finished command |
| eng_rx_data | input | 8 | Byte received by the engine |
| eng_cmd_valid | output | 1 | One-cycle command strobe |
| eng_cmd | output | 3 | Command code |
| eng_tx_byte | output | 8 | Byte to send with WRITE |
| eng_ack | output | 1 | Acknowledge to return with READ |
| rx_valid | output | 1 | Received byte strobe |
| rx_data | output | 8 | Received byte |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | Sticky: transaction completed |
| nack_error | output | 1 | Sticky: slave did not acknowledge |
| arb_lost_retry | output | 1 | Sticky: arbitration lost, retry taken |
| timeout | output | 1 | Sticky: transaction aborted by the timer |

## Verification
Each command leaves the block one cycle after the clock edge that samples `start` or `eng_done`. A received byte and the change of a status flag appear in that same cycle. The bench's engine model compares every command and received byte on the falling edge after the strobe, against queues filled from the requirements. Flag values are checked only once `busy` has dropped and the expected-command queue is empty. The arbitration case also checks that no command leaves while `bus_free` is low.

// File: rtl/i2c_xfer_seq_pkg.sv
package i2c_xfer_seq_pkg;
   typedef enum logic [2:0] {
      CMD_NONE    = 3'd0,
      CMD_START   = 3'd1,
      CMD_WRITE   = 3'd2,
      CMD_READ    = 3'd3,
      CMD_STOP    = 3'd4,
      CMD_RELEASE = 3'd5
   } eng_cmd_t;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,
      ST_ARB  = 2'd2
   } seq_state_t;

   localparam logic [7:0] SC_BUS_ERR   = 8'h00;
   localparam logic [7:0] SC_START     = 8'h08;
   localparam logic [7:0] SC_RESTART   = 8'h10;
   localparam logic [7:0] SC_AW_ACK    = 8'h18;
   localparam logic [7:0] SC_AW_NACK   = 8'h20;
   localparam logic [7:0] SC_DW_ACK    = 8'h28;
   localparam logic [7:0] SC_DW_NACK   = 8'h30;
   localparam logic [7:0] SC_ARB_LOST  = 8'h38;
   localparam logic [7:0] SC_AR_ACK    = 8'h40;
   localparam logic [7:0] SC_AR_NACK   = 8'h48;
   localparam logic [7:0] SC_DR_ACK    = 8'h50;
   localparam logic [7:0] SC_DR_NACK   = 8'h58;

   localparam int FLAG_DONE = 0;
   localparam int FLAG_NACK = 1;
   localparam int FLAG_ARB  = 2;
   localparam int FLAG_TO   = 3;
   localparam int NFLAGS    = 4;
endpackage

// File: rtl/i2c_xfer_seq_buf.sv
module i2c_xfer_seq_buf #(
   parameter int DEPTH = 8,
   parameter int WIDTH = 8,
   localparam int IW = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [IW-1:0]    waddr,
   input  logic [WIDTH-1:0] wdata,
   input  logic [IW-1:0]    raddr,
   output logic [WIDTH-1:0] rdata
);
   logic [WIDTH-1:0] mem_q [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_entry
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                        mem_q[g] <= '0;
         else if (we && waddr == IW'(g))    mem_q[g] <= wdata;
      end
   end

   assign rdata = mem_q[raddr];
endmodule

// File: rtl/i2c_xfer_seq_timer.sv
module i2c_xfer_seq_timer #(
   parameter bit TIMEOUT_EN     = 1'b1,
   parameter int TIMEOUT_CYCLES = 100000,
   localparam int TW = $clog2(TIMEOUT_CYCLES + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic expire
);
   if (TIMEOUT_EN) begin : g_timer
      logic [TW-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      cnt_q <= '0;
         else if (!run)   cnt_q <= '0;
         else if (!expire) cnt_q <= cnt_q + TW'(1);
      end
      assign expire = run && (cnt_q == TW'(TIMEOUT_CYCLES - 1));
   end else begin : g_no_timer
      logic unused_tmr;
      assign unused_tmr = clk ^ rst_n ^ run;
      assign expire = 1'b0;
   end
endmodule

// File: rtl/i2c_xfer_seq_flags.sv
module i2c_xfer_seq_flags #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic         clr,
   output logic [N-1:0] flags
);
   for (genvar g = 0; g < N; g++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       flags[g] <= 1'b0;
         else if (set[g])  flags[g] <= 1'b1;
         else if (clr)     flags[g] <= 1'b0;
      end

      p_flag_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
         flags[g] && !clr |=> flags[g]);
   end
endmodule

// File: rtl/i2c_xfer_seq.sv
module i2c_xfer_seq
   import i2c_xfer_seq_pkg::*;
#(
   parameter int DEPTH          = 8,
   parameter bit TIMEOUT_EN     = 1'b1,
   parameter int TIMEOUT_CYCLES = 100000,
   localparam int CW = $clog2(DEPTH + 1),
   localparam int IW = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [7:0]    slave_addr,
   input  logic [CW-1:0] byte_count,
   input  logic          rep_start_en,
   input  logic          buf_we,
   input  logic [IW-1:0] buf_waddr,
   input  logic [7:0]    buf_wdata,
   input  logic          clear_status,
   input  logic          bus_free,
   input  logic          eng_done,
   input  logic [7:0]    eng_status,
   input  logic [7:0]    eng_rx_data,
   output logic          eng_cmd_valid,
   output logic [2:0]    eng_cmd,
   output logic [7:0]    eng_tx_byte,
   output logic          eng_ack,
   output logic          rx_valid,
   output logic [7:0]    rx_data,
   output logic          busy,
   output logic          done,
   output logic          nack_error,
   output logic          arb_lost_retry,
   output logic          timeout
);
   if (DEPTH < 2 || (1 << IW) != DEPTH) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (TIMEOUT_EN && TIMEOUT_CYCLES < 2) begin : g_bad_to
      $error("TIMEOUT_CYCLES must be at least 2");
   end

   seq_state_t    st_q, st_d;
   logic [7:0]    addr_q;
   logic [CW-1:0] cnt_q, rem_q, rem_d;
   logic [IW-1:0] idx_q, idx_d;
   logic          rep_q, end_q, end_d;
   logic [7:0]    buf_rdata;
   logic          to_expire;
   logic [NFLAGS-1:0] flag_set, flag_q;
   eng_cmd_t      cmd_d;
   logic [7:0]    tx_d;
   logic          ack_d, rxv_d;

   i2c_xfer_seq_buf #(.DEPTH(DEPTH), .WIDTH(8)) u_buf (
      .clk(clk), .rst_n(rst_n), .we(buf_we), .waddr(buf_waddr),
      .wdata(buf_wdata), .raddr(idx_q), .rdata(buf_rdata));

   i2c_xfer_seq_timer #(.TIMEOUT_EN(TIMEOUT_EN), .TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_timer (
      .clk(clk), .rst_n(rst_n), .run(st_q != ST_IDLE), .expire(to_expire));

   i2c_xfer_seq_flags #(.N(NFLAGS)) u_flags (
      .clk(clk), .rst_n(rst_n), .set(flag_set), .clr(clear_status), .flags(flag_q));

   always_comb begin
      st_d     = st_q;
      rem_d    = rem_q;
      idx_d    = idx_q;
      end_d    = end_q;
      cmd_d    = CMD_NONE;
      tx_d     = 8'h00;
      ack_d    = 1'b0;
      rxv_d    = 1'b0;
      flag_set = '0;
      unique case (st_q)
         ST_IDLE: begin
            if (start) begin
               cmd_d = CMD_START;
               end_d = 1'b0;
               st_d  = ST_WAIT;
            end
         end
         ST_WAIT: begin
            if (to_expire) begin
               cmd_d = CMD_RELEASE;
               flag_set[FLAG_TO] = 1'b1;
               st_d  = ST_IDLE;
            end else if (eng_done) begin
               case (eng_status)
                  SC_START, SC_RESTART: begin
                     if (end_q) begin
                        flag_set[FLAG_DONE] = 1'b1;
                        st_d = ST_IDLE;
                     end else begin
                        cmd_d = CMD_WRITE;
                        tx_d  = addr_q;
                        rem_d = cnt_q;
                        idx_d = '0;
                     end
                  end
                  SC_AW_ACK, SC_DW_ACK: begin
                     if (eng_status == SC_DW_ACK) rem_d = rem_q - CW'(1);
                     if (rem_d == '0) begin
                        if (rep_q && eng_status == SC_DW_ACK) begin
                           cmd_d = CMD_START;
                           end_d = 1'b1;
                        end else begin
                           cmd_d = CMD_STOP;
                           flag_set[FLAG_DONE] = 1'b1;
                           st_d  = ST_IDLE;
                        end
                     end else begin
                        cmd_d = CMD_WRITE;
                        tx_d  = buf_rdata;
                        idx_d = idx_q + IW'(1);
                     end
                  end
                  SC_AR_ACK, SC_DR_ACK, SC_DR_NACK: begin
                     if (eng_status != SC_AR_ACK) begin
                        rxv_d = 1'b1;
                        rem_d = (eng_status == SC_DR_NACK) ? '0 : rem_q - CW'(1);
                     end
                     if (rem_d == '0) begin
                        if (rep_q && eng_status != SC_AR_ACK) begin
                           cmd_d = CMD_START;
                           end_d = 1'b1;
                        end else begin
                           cmd_d = CMD_STOP;
                           flag_set[FLAG_DONE] = 1'b1;
                           st_d  = ST_IDLE;
                        end
                     end else begin
                        cmd_d = CMD_READ;
                        ack_d = (rem_d > CW'(1));
                     end
                  end
                  SC_AW_NACK, SC_DW_NACK, SC_AR_NACK: begin
                     cmd_d = CMD_STOP;
                     flag_set[FLAG_NACK] = 1'b1;
                     st_d  = ST_IDLE;
                  end
                  SC_ARB_LOST: begin
                     flag_set[FLAG_ARB] = 1'b1;
                     st_d  = ST_ARB;
                  end
                  default: begin
                     cmd_d = CMD_RELEASE;
                     st_d  = ST_IDLE;
                  end
               endcase
            end
         end
         ST_ARB: begin
            if (to_expire) begin
               cmd_d = CMD_RELEASE;
               flag_set[FLAG_TO] = 1'b1;
               st_d  = ST_IDLE;
            end else if (bus_free) begin
               cmd_d = CMD_START;
               st_d  = ST_WAIT;
            end
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q          <= ST_IDLE;
         addr_q        <= '0;
         cnt_q         <= '0;
         rep_q         <= 1'b0;
         rem_q         <= '0;
         idx_q         <= '0;
         end_q         <= 1'b0;
         eng_cmd_valid <= 1'b0;
         eng_cmd       <= CMD_NONE;
         eng_tx_byte   <= '0;
         eng_ack       <= 1'b0;
         rx_valid      <= 1'b0;
         rx_data       <= '0;
      end else begin
         if (st_q == ST_IDLE && start) begin
            addr_q <= slave_addr;
            cnt_q  <= byte_count;
            rep_q  <= rep_start_en;
         end
         st_q          <= st_d;
         rem_q         <= rem_d;
         idx_q         <= idx_d;
         end_q         <= end_d;
         eng_cmd_valid <= (cmd_d != CMD_NONE);
         eng_cmd       <= cmd_d;
         eng_tx_byte   <= tx_d;
         eng_ack       <= ack_d;
         rx_valid      <= rxv_d;
         if (rxv_d) rx_data <= eng_rx_data;
      end
   end

   assign busy           = (st_q != ST_IDLE);
   assign done           = flag_q[FLAG_DONE];
   assign nack_error     = flag_q[FLAG_NACK];
   assign arb_lost_retry = flag_q[FLAG_ARB];
   assign timeout        = flag_q[FLAG_TO];

   p_idle_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      eng_cmd_valid && eng_cmd == CMD_START && !$past(busy) |-> $past(start));
   p_arb_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(st_q == ST_ARB && !bus_free) |-> !eng_cmd_valid);
   p_nack_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(nack_error) |-> eng_cmd_valid && eng_cmd == CMD_STOP && !busy);
   p_timeout_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(timeout) |-> eng_cmd_valid && eng_cmd == CMD_RELEASE && !busy);
   p_done_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> !busy);
   p_rx_from_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> $past(eng_done) && $past(busy));
endmodule

// File: tb/i2c_xfer_seq_tb.sv
module i2c_xfer_seq_tb;
   localparam int DEPTH = 8;
   localparam int CW = $clog2(DEPTH + 1);
   localparam int IW = $clog2(DEPTH);
   localparam int TO = 96;

   logic clk = 1'b0, rst_n = 1'b0;
   logic start = 0, rep_start_en = 0, buf_we = 0, clear_status = 0, bus_free = 1;
   logic [7:0] slave_addr = 0, buf_wdata = 0, eng_status = 0, eng_rx_data = 0;
   logic [CW-1:0] byte_count = 0;
   logic [IW-1:0] buf_waddr = 0;
   logic eng_done = 0;
   logic eng_cmd_valid, eng_ack, rx_valid, busy, done, nack_error, arb_lost_retry, timeout;
   logic [2:0] eng_cmd;
   logic [7:0] eng_tx_byte, rx_data;

   always #2.5 clk = ~clk;

   i2c_xfer_seq #(.DEPTH(DEPTH), .TIMEOUT_EN(1'b1), .TIMEOUT_CYCLES(TO)) u_dut (.*);

   int n_chk = 0, n_fail = 0;
   int exp_q[$], rsp_q[$], rx_q[$];
   string cur_req = "R1";
   int pend_cnt = 0, pend_s = 0, pend_d = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic int cw(input int c, input int b, input int a);
      return (c << 16) | (a << 8) | b;
   endfunction

   task automatic ecmd(input int c, input int b = 0, input int a = 0);
      exp_q.push_back(cw(c, b, a));
   endtask

   // engine model and scoreboard monitor
   always @(negedge clk) begin
      eng_done = 1'b0;
      if (pend_cnt > 0) begin
         pend_cnt--;
         if (pend_cnt == 0) begin
            eng_done = 1'b1;
            eng_status = 8'(pend_s);
            eng_rx_data = 8'(pend_d);
         end
      end
      if (rst_n && eng_cmd_valid) begin
         int act, e;
         act = cw(int'(eng_cmd), (eng_cmd == 3'd2) ? int'(eng_tx_byte) : 0,
                  (eng_cmd == 3'd3) ? int'(eng_ack) : 0);
         if (exp_q.size() == 0) chk(1'b0, cur_req, act, -1);
         else begin
            e = exp_q.pop_front();
            chk(act == e, cur_req, act, e);
         end
         if (eng_cmd inside {3'd1, 3'd2, 3'd3} && rsp_q.size() > 0) begin
            int r;
            r = rsp_q.pop_front();
            if (r >= 0) begin
               pend_s = r & 255;
               pend_d = (r >> 8) & 255;
               pend_cnt = 2;
            end
         end
      end
      if (rst_n && rx_valid) begin
         if (rx_q.size() == 0) chk(1'b0, "R4", int'(rx_data), -1);
         else begin
            int e;
            e = rx_q.pop_front();
            chk(int'(rx_data) == e, "R4", int'(rx_data), e);
         end
      end
   end

   task automatic load(input int i, input int d);
      @(negedge clk);
      buf_we = 1; buf_waddr = IW'(i); buf_wdata = 8'(d);
      @(negedge clk);
      buf_we = 0;
   endtask

   task automatic go(input int a, input int n, input bit rep);
      @(negedge clk);
      start = 1; slave_addr = 8'(a); byte_count = CW'(n); rep_start_en = rep;
      @(negedge clk);
      start = 0;
   endtask

   task automatic wait_idle;
      int k;
      k = 0;
      while ((busy || exp_q.size() != 0) && k < 400) begin
         @(negedge clk);
         k++;
      end
      repeat (3) @(negedge clk);
      chk(k < 400, {cur_req, " watchdog"}, k, 400);
      chk(exp_q.size() == 0 && rx_q.size() == 0, cur_req, exp_q.size(), 0);
   endtask

   task automatic flags(input string req, input int exp);
      int act;
      act = {28'd0, timeout, arb_lost_retry, nack_error, done};
      chk(act == exp, req, act, exp);
   endtask

   task automatic clr;
      @(negedge clk);
      clear_status = 1;
      @(negedge clk);
      clear_status = 0;
      flags("R11", 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      chk(1'b0, "watchdog", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(!busy && !eng_cmd_valid, "R1", {busy, eng_cmd_valid}, 0);
      flags("R1", 0);
      rst_n = 1;
      repeat (2) @(negedge clk);
      chk(!busy && !eng_cmd_valid, "R1", {busy, eng_cmd_valid}, 0);

      load(0, 8'h3C); load(1, 8'hC5); load(2, 8'h7E);

      // R3: write 3 bytes, R2 start during busy ignored
      cur_req = "R3";
      ecmd(1); ecmd(2, 8'hA0); ecmd(2, 8'h3C); ecmd(2, 8'hC5); ecmd(2, 8'h7E); ecmd(4);
      rsp_q = {8'h08, 8'h18, 8'h28, 8'h28, 8'h28};
      go(8'hA0, 3, 0);
      repeat (3) @(negedge clk);
      start = 1; slave_addr = 8'h55; byte_count = 0;   // R2: must be ignored
      @(negedge clk); start = 0;
      wait_idle();
      flags("R3", 1);
      repeat (20) @(negedge clk);
      flags("R11", 1);   // held
      clr();

      // R4: read 3 bytes
      cur_req = "R4";
      ecmd(1); ecmd(2, 8'hA1); ecmd(3, 0, 1); ecmd(3, 0, 1); ecmd(3, 0, 0); ecmd(4);
      rsp_q = {8'h08, 8'h40, 'h1150, 'h2250, 'h3358};
      rx_q = {8'h11, 8'h22, 8'h33};
      go(8'hA1, 3, 0);
      wait_idle();
      flags("R4", 1);
      clr();

      // R5: zero count
      cur_req = "R5";
      ecmd(1); ecmd(2, 8'hA0); ecmd(4);
      rsp_q = {8'h08, 8'h18};
      go(8'hA0, 0, 0);
      wait_idle();
      flags("R5", 1);
      clr();

      // R6: address NACK and data NACK
      cur_req = "R6";
      ecmd(1); ecmd(2, 8'hA0); ecmd(4);
      rsp_q = {8'h08, 8'h20};
      go(8'hA0, 2, 0);
      wait_idle();
      flags("R6", 2);
      clr();
      ecmd(1); ecmd(2, 8'hA0); ecmd(2, 8'h3C); ecmd(4);
      rsp_q = {8'h08, 8'h18, 8'h30};
      go(8'hA0, 2, 0);
      wait_idle();
      flags("R6", 2);
      clr();

      // R7: arbitration lost, wait for free bus, restart
      cur_req = "R7";
      bus_free = 0;
      ecmd(1); ecmd(2, 8'hA0);
      rsp_q = {8'h08, 8'h18, 8'h38};
      ecmd(2, 8'h3C);
      go(8'hA0, 2, 0);
      repeat (30) @(negedge clk);
      chk(busy && exp_q.size() == 0, "R7", {busy, 1'b0}, 2);
      flags("R7", 4);
      ecmd(1); ecmd(2, 8'hA0); ecmd(2, 8'h3C); ecmd(2, 8'hC5); ecmd(4);
      rsp_q = {8'h10, 8'h18, 8'h28, 8'h28};
      bus_free = 1;
      wait_idle();
      flags("R7", 5);
      clr();

      // R8: bus error
      cur_req = "R8";
      ecmd(1); ecmd(2, 8'hA0); ecmd(5);
      rsp_q = {8'h08, 8'h00};
      go(8'hA0, 2, 0);
      wait_idle();
      flags("R8", 0);

      // R9: repeated START after write and after read
      cur_req = "R9";
      ecmd(1); ecmd(2, 8'hA0); ecmd(2, 8'h3C); ecmd(1);
      rsp_q = {8'h08, 8'h18, 8'h28, 8'h10};
      go(8'hA0, 1, 1);
      wait_idle();
      flags("R9", 1);
      clr();
      ecmd(1); ecmd(2, 8'hA1); ecmd(3, 0, 0); ecmd(1);
      rsp_q = {8'h08, 8'h40, 'h9A58, 8'h10};
      rx_q = {8'h9A};
      go(8'hA1, 1, 1);
      wait_idle();
      flags("R9", 1);
      clr();

      // R10: timeout
      cur_req = "R10";
      ecmd(1); ecmd(2, 8'hA0); ecmd(5);
      rsp_q = {8'h08, -1};
      go(8'hA0, 2, 0);
      repeat (TO - 20) @(negedge clk);
      chk(busy && !timeout, "R10", {busy, timeout}, 2);
      wait_idle();
      flags("R10", 8);
      clr();

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule